// File: doc/BRIEF.md
# Per-Channel Secure and Privileged Register Access Filter

This block sits between a bus slave port and a per-channel register file. Every channel owns one configuration register and one bit in each of two shared registers (an overrun status register and a write-1-to-clear register). Each channel carries a secure attribute and a privileged attribute that arrive as vectors from outside. The filter checks each bus access against the attributes of the channel that owns the target register or bit. It then produces a write enable with a bit-level write mask and masked read data. When a non-secure access reaches a secure channel's register, it raises a one-cycle illegal-access pulse.

Accesses follow an address phase and a data phase. Address, direction, size and the two security qualifiers are sampled at the clock edge on which `a_valid` is high. The filtered outputs then hold for the one cycle that follows that edge. The register file uses `acc_index` to select its word, returns that word on `rf_rdata`, and applies `wr_mask` when `wr_en` is high. The block also merges the per-channel overrun flags into one interrupt for secure channels and one for non-secure channels.

Top module: `chan_access_filter`

## Requirements
- R1: After reset, and in any cycle that does not follow an accepted address phase, `wr_en` is 0, `wr_mask` and `rd_data` are 0, and `illegal_pulse` is 0.
- R2: An access is secure when `a_nonsec` is 0 and privileged when `a_priv` is 1, both sampled in the address phase. An access allowed to reach channel register c (byte address 4*c, c < NCH) gets its results in the next cycle: `acc_index` equals the word address, a write gives `wr_en`=1 with `wr_mask` covering the addressed bytes, and a read returns `rf_rdata` masked to those bytes.
- R3: An unprivileged access (`a_priv`=0) to the register of a channel whose `ch_priv` bit is 1 has its write dropped (`wr_en`=0) and its read returned as zero.
- R4: A non-secure access (`a_nonsec`=1) to the register of a channel whose `ch_sec` bit is 1 has its write dropped and its read returned as zero. `illegal_pulse` is 1 for exactly the data-phase cycle of that access.
- R5: In the shared status register (word NCH) and the shared clear register (word NCH+1), bit i belongs to channel i. Each bit is masked for reads and writes with the same secure and privileged rules as that channel. Bits at or above NCH are always masked. Accesses to these two words never raise `illegal_pulse`, even when every channel is secure.
- R6: Byte (`a_size`=0), half-word (1) and word (2) accesses are accepted when the address is aligned to their size, and they cover byte lanes starting at `a_addr[1:0]`. A misaligned access or `a_size`=3 gives no write and a zero read.
- R7: The status register is read-only and never yields `wr_en`. The clear register is write-only and always reads as zero.
- R8: An access to any word above NCH+1 gives no write, a zero read and no illegal pulse.
- R9: `irq_sec` is the OR of `ovr_flag` bits of channels with `ch_sec`=1, and `irq_nsec` is the OR of those with `ch_sec`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Address phase of an access is present |
| a_addr | input | ADDR_W | Byte address |
| a_write | input | 1 | 1 = write, 0 = read |
| a_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| a_nonsec | input | 1 | 1 = non-secure access |
| a_priv | input | 1 | 1 = privileged access |
| ch_sec | input | NCH | Secure attribute per channel |
| ch_priv | input | NCH | Privileged attribute per channel |
| ovr_flag | input | NCH | Overrun flag per channel |
| rf_rdata | input | 32 | Raw word from the register file at `acc_index` |
| acc_index | output | ADDR_W-2 | Word address of the access in data phase |
| wr_en | output | 1 | Filtered write enable |
| wr_mask | output | 32 | Bits the register file may update |
| rd_data | output | 32 | Filtered read data |
| illegal_pulse | output | 1 | One-cycle illegal-access pulse |
| irq_sec | output | 1 | Overrun interrupt, secure channels |
| irq_nsec | output | 1 | Overrun interrupt, non-secure channels |

## Verification
A stale or wrong data-phase register would show in the very next cycle as a write mask, read value or illegal pulse that belongs to a different address, size or qualifier. A wrong per-channel permission bit would show at once, either as a leaked bit in a shared-register read or as a write mask bit on a protected channel. The bench compares all filtered outputs and both interrupts against a behavioural model on every clock. It uses directed accesses and then many mixed accesses under changing attribute vectors, so an error is reported in the cycle it first appears.

// File: rtl/chan_acf_pkg.sv
// Shared types for the channel access filter.
// Assumes: access sizes are coded 0..2, with 3 reserved.
package chan_acf_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        K_CHAN = 2'd0,
        K_STAT = 2'd1,
        K_CLR  = 2'd2,
        K_NONE = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/acf_lane_dec.sv
// Byte-lane decoder: turns size and low address bits into a lane mask and
// an alignment flag. Assumes a 4-byte data bus.
module acf_lane_dec
    import chan_acf_pkg::*;
(
    input  acc_size_e   size,
    input  logic [1:0]  off,
    output logic [3:0]  lanes,
    output logic        aligned
);
    // Decode the lanes touched and whether the access is size-aligned.
    always_comb begin
        lanes   = 4'b0000;
        aligned = 1'b0;
        unique case (size)
            SZ_BYTE: begin
                aligned = 1'b1;
                lanes   = 4'b0001 << off;
            end
            SZ_HALF: begin
                aligned = (off[0] == 1'b0);
                lanes   = off[1] ? 4'b1100 : 4'b0011;
            end
            SZ_WORD: begin
                aligned = (off == 2'b00);
                lanes   = 4'b1111;
            end
            default: begin
                aligned = 1'b0;
                lanes   = 4'b0000;
            end
        endcase
    end
endmodule

// File: rtl/acf_perm.sv
// Permission evaluator: per-channel allow bits for the current access, the
// verdict for the owning channel of a configuration register, and the
// illegal-access condition. Assumes chan < NCH whenever kind is K_CHAN.
module acf_perm
    import chan_acf_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int IDX_W = $clog2(NCH)
) (
    input  reg_kind_e          kind,
    input  logic [IDX_W-1:0]   chan,
    input  logic               nonsec,
    input  logic               priv,
    input  logic [NCH-1:0]     ch_sec,
    input  logic [NCH-1:0]     ch_priv,
    output logic [NCH-1:0]     bit_ok,
    output logic               chan_ok,
    output logic               chan_illegal
);
    // One allow bit per channel from its secure and privileged attributes.
    for (genvar i = 0; i < NCH; i++) begin : g_ok
        assign bit_ok[i] = (!nonsec || !ch_sec[i]) && (priv || !ch_priv[i]);
    end

    // Verdict for a configuration register owned by a single channel.
    always_comb begin
        chan_ok      = (kind == K_CHAN) && bit_ok[chan];
        chan_illegal = (kind == K_CHAN) && nonsec && ch_sec[chan];
    end
endmodule

// File: rtl/chan_access_filter.sv
// Access filter in front of a per-channel register file. It samples the
// address phase, then in the data phase gives a write enable with a bit
// mask, masked read data and an illegal-access pulse. Word c < NCH is the
// configuration register of channel c. Word NCH is the shared status
// register and word NCH+1 is the shared write-1-to-clear register.
// Assumes NCH <= 32 and NCH is a power of two.
module chan_access_filter
    import chan_acf_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 a_valid,
    input  logic [ADDR_W-1:0]    a_addr,
    input  logic                 a_write,
    input  logic [1:0]           a_size,
    input  logic                 a_nonsec,
    input  logic                 a_priv,
    input  logic [NCH-1:0]       ch_sec,
    input  logic [NCH-1:0]       ch_priv,
    input  logic [NCH-1:0]       ovr_flag,
    input  logic [31:0]          rf_rdata,
    output logic [ADDR_W-3:0]    acc_index,
    output logic                 wr_en,
    output logic [31:0]          wr_mask,
    output logic [31:0]          rd_data,
    output logic                 illegal_pulse,
    output logic                 irq_sec,
    output logic                 irq_nsec
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int IDX_W  = $clog2(NCH);
    localparam logic [WORD_W-1:0] STAT_WORD = WORD_W'(NCH);
    localparam logic [WORD_W-1:0] CLR_WORD  = WORD_W'(NCH + 1);

    logic [WORD_W-1:0] a_word;
    reg_kind_e         a_kind;
    logic [IDX_W-1:0]  a_chan;
    logic [3:0]        a_lanes;
    logic              a_aligned;

    logic              d_valid, d_write, d_aligned, d_nonsec, d_priv;
    reg_kind_e         d_kind;
    logic [IDX_W-1:0]  d_chan;
    logic [WORD_W-1:0] d_word;
    logic [3:0]        d_lanes;

    logic [NCH-1:0]    bit_ok;
    logic              chan_ok, chan_illegal;
    logic [31:0]       lane_bits, shared_bits, field_mask;

    assign a_word = a_addr[ADDR_W-1:2];
    assign a_chan = a_word[IDX_W-1:0];

    // Classify the addressed word in the address phase.
    always_comb begin
        if (a_word < STAT_WORD)      a_kind = K_CHAN;
        else if (a_word == STAT_WORD) a_kind = K_STAT;
        else if (a_word == CLR_WORD)  a_kind = K_CLR;
        else                          a_kind = K_NONE;
    end

    acf_lane_dec u_lane (
        .size    (acc_size_e'(a_size)),
        .off     (a_addr[1:0]),
        .lanes   (a_lanes),
        .aligned (a_aligned)
    );

    // Hold the sampled address phase for the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_valid   <= 1'b0;
            d_write   <= 1'b0;
            d_aligned <= 1'b0;
            d_nonsec  <= 1'b0;
            d_priv    <= 1'b0;
            d_kind    <= K_NONE;
            d_chan    <= '0;
            d_word    <= '0;
            d_lanes   <= '0;
        end else begin
            d_valid   <= a_valid;
            d_write   <= a_write;
            d_aligned <= a_aligned;
            d_nonsec  <= a_nonsec;
            d_priv    <= a_priv;
            d_kind    <= a_kind;
            d_chan    <= a_chan;
            d_word    <= a_word;
            d_lanes   <= a_lanes;
        end
    end

    acf_perm #(.NCH(NCH), .IDX_W(IDX_W)) u_perm (
        .kind         (d_kind),
        .chan         (d_chan),
        .nonsec       (d_nonsec),
        .priv         (d_priv),
        .ch_sec       (ch_sec),
        .ch_priv      (ch_priv),
        .bit_ok       (bit_ok),
        .chan_ok      (chan_ok),
        .chan_illegal (chan_illegal)
    );

    // Spread each byte-lane bit over its eight data bits.
    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign lane_bits[b*8 +: 8] = {8{d_lanes[b]}};
    end

    // Shared-register bits exist only for implemented channels.
    for (genvar j = 0; j < 32; j++) begin : g_shared
        if (j < NCH) begin : g_live
            assign shared_bits[j] = bit_ok[j];
        end else begin : g_dead
            assign shared_bits[j] = 1'b0;
        end
    end

    // Combine lanes and field ownership into the data-phase bit mask.
    always_comb begin
        field_mask = '0;
        if (d_valid && d_aligned) begin
            unique case (d_kind)
                K_CHAN:       field_mask = chan_ok ? lane_bits : '0;
                K_STAT, K_CLR: field_mask = lane_bits & shared_bits;
                default:      field_mask = '0;
            endcase
        end
    end

    // Drive the filtered write, read and illegal-access outputs.
    always_comb begin
        wr_en         = d_valid && d_write && (d_kind == K_CHAN || d_kind == K_CLR)
                        && (field_mask != '0);
        wr_mask       = wr_en ? field_mask : '0;
        rd_data       = (d_valid && !d_write && d_kind != K_CLR) ? (rf_rdata & field_mask) : '0;
        illegal_pulse = d_valid && chan_illegal;
        acc_index     = d_word;
    end

    // Merge overrun flags by channel security.
    always_comb begin
        irq_sec  = |(ovr_flag & ch_sec);
        irq_nsec = |(ovr_flag & ~ch_sec);
    end

    p_pulse_needs_nonsec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_pulse |-> $past(a_valid && a_nonsec));

    p_unpriv_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(a_valid && !a_priv && a_kind == K_CHAN && ch_priv[a_chan]) && $stable(ch_priv))
        |-> (!wr_en && rd_data == '0));

    p_shared_no_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(a_valid && (a_kind == K_STAT || a_kind == K_CLR)) |-> !illegal_pulse);

    p_misaligned_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(a_valid && !a_aligned) |-> (!wr_en && rd_data == '0));

    p_status_readonly_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(a_kind != K_STAT));

    p_unmapped_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(a_valid && a_kind == K_NONE) |-> (!wr_en && rd_data == '0 && !illegal_pulse));
endmodule

// File: tb/chan_access_filter_test.sv
module chan_access_filter_test;
    localparam int NCH = 16;
    localparam logic [31:0] RF = 32'h5AC3_E71B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_valid = 1'b0;
    logic [7:0]  a_addr = '0;
    logic        a_write = 1'b0;
    logic [1:0]  a_size = '0;
    logic        a_nonsec = 1'b0;
    logic        a_priv = 1'b1;
    logic [15:0] ch_sec = '0;
    logic [15:0] ch_priv = '0;
    logic [15:0] ovr_flag = '0;
    logic [31:0] rf_rdata;
    logic [5:0]  acc_index;
    logic        wr_en, illegal_pulse, irq_sec, irq_nsec;
    logic [31:0] wr_mask, rd_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // model state captured at each clock edge
    bit m_v, m_w, m_ns, m_pv;
    int m_addr, m_sz;

    assign rf_rdata = RF;

    always #5 clk = ~clk;

    chan_access_filter #(.NCH(NCH), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_addr(a_addr),
        .a_write(a_write), .a_size(a_size), .a_nonsec(a_nonsec), .a_priv(a_priv),
        .ch_sec(ch_sec), .ch_priv(ch_priv), .ovr_flag(ovr_flag), .rf_rdata(rf_rdata),
        .acc_index(acc_index), .wr_en(wr_en), .wr_mask(wr_mask), .rd_data(rd_data),
        .illegal_pulse(illegal_pulse), .irq_sec(irq_sec), .irq_nsec(irq_nsec)
    );

    always @(posedge clk) begin
        if (!rst_n) m_v <= 0;
        else begin
            m_v <= a_valid; m_w <= a_write; m_ns <= a_nonsec; m_pv <= a_priv;
            m_addr <= int'(a_addr); m_sz <= int'(a_size);
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic void model(output bit e_wr, output logic [31:0] e_mask,
                                  output logic [31:0] e_rd, output bit e_ill,
                                  output string tag);
        int word, off, n;
        bit ok;
        logic [31:0] lanes_m, own;
        e_wr = 0; e_mask = 0; e_rd = 0; e_ill = 0; tag = "R1";
        if (!m_v) return;
        word = m_addr / 4;
        off  = m_addr % 4;
        ok = (m_sz == 0) || (m_sz == 1 && off % 2 == 0) || (m_sz == 2 && off == 0);
        n = (m_sz == 0) ? 1 : (m_sz == 1) ? 2 : 4;
        lanes_m = 0;
        if (ok) for (int b = off; b < off + n; b++) lanes_m[b*8 +: 8] = 8'hFF;
        if (word < NCH) begin
            e_ill = m_ns && ch_sec[word];
            tag = e_ill ? "R4" : (!m_pv && ch_priv[word]) ? "R3" : "R2";
            if (!(m_ns && ch_sec[word]) && (m_pv || !ch_priv[word])) e_mask = lanes_m;
            e_wr = m_w && (e_mask != 0);
            e_rd = m_w ? 32'h0 : (RF & e_mask);
        end else if (word == NCH || word == NCH + 1) begin
            tag = ((m_w && word == NCH) || (!m_w && word == NCH + 1)) ? "R7" : "R5";
            own = 0;
            for (int i = 0; i < NCH; i++)
                if (!(m_ns && ch_sec[i]) && (m_pv || !ch_priv[i])) own[i] = 1'b1;
            e_mask = lanes_m & own;
            e_wr = m_w && (word == NCH + 1) && (e_mask != 0);
            e_rd = (!m_w && word == NCH) ? (RF & e_mask) : 32'h0;
        end else begin
            tag = "R8";
        end
        if (!ok) tag = "R6";
        if (!e_wr) e_mask = 0;
    endfunction

    // one clock: compare all outputs with the model, away from the edge
    task automatic step();
        bit e_wr, e_ill;
        logic [31:0] e_mask, e_rd;
        string tag;
        bit es, en;
        @(negedge clk);
        model(e_wr, e_mask, e_rd, e_ill, tag);
        checks++;
        if (wr_en !== e_wr || wr_mask !== e_mask || rd_data !== e_rd ||
            illegal_pulse !== e_ill || (m_v && acc_index !== 6'(m_addr / 4))) begin
            failures++;
            $display("FAIL %s addr=%0h wr=%0b sz=%0d ns=%0b pv=%0b: got we=%0b m=%h rd=%h il=%0b idx=%0d exp we=%0b m=%h rd=%h il=%0b",
                     tag, m_addr, m_w, m_sz, m_ns, m_pv, wr_en, wr_mask, rd_data,
                     illegal_pulse, acc_index, e_wr, e_mask, e_rd, e_ill);
        end
        es = |(ovr_flag & ch_sec);
        en = |(ovr_flag & ~ch_sec);
        checks++;
        if (irq_sec !== es || irq_nsec !== en) begin
            failures++;
            $display("FAIL R9 got sec=%0b nsec=%0b exp sec=%0b nsec=%0b", irq_sec, irq_nsec, es, en);
        end
    endtask

    task automatic acc(input int addr, input bit w, input int sz, input bit ns, input bit pv);
        a_valid = 1; a_addr = 8'(addr); a_write = w; a_size = 2'(sz);
        a_nonsec = ns; a_priv = pv;
        step();
        a_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: quiet outputs right after reset
        step();
        step();
        ch_sec = 16'hF0F0; ch_priv = 16'h3C3C; ovr_flag = 16'h0101;
        step();
        acc(32'h00, 1, 2, 0, 1);   // R2 secure word write ch0
        acc(32'h11, 0, 0, 0, 1);   // R2 byte read ch4 lane1
        acc(32'h16, 1, 1, 0, 1);   // R2 half write upper lanes
        acc(32'h08, 1, 2, 0, 0);   // R3 unprivileged write to privileged ch2
        acc(32'h08, 0, 2, 0, 0);   // R3 read
        acc(32'h10, 1, 2, 1, 1);   // R4 nonsec write to secure ch4
        acc(32'h10, 0, 2, 1, 1);   // R4 read
        step();
        acc(32'h40, 0, 2, 1, 1);   // R5 nonsec status read
        acc(32'h44, 1, 2, 1, 0);   // R5 clear write, unpriv nonsec
        acc(32'h02, 1, 2, 0, 1);   // R6 misaligned word
        acc(32'h01, 1, 1, 0, 1);   // R6 misaligned half
        acc(32'h00, 1, 3, 0, 1);   // R6 reserved size
        acc(32'h40, 1, 2, 0, 1);   // R7 status write ignored
        acc(32'h44, 0, 2, 0, 1);   // R7 clear read zero
        acc(32'h48, 1, 2, 0, 1);   // R8 unmapped
        acc(32'h4C, 0, 2, 1, 0);   // R8 unmapped nonsec
        ch_sec = 16'hFFFF;
        acc(32'h40, 0, 2, 1, 1);   // R5 all secure: no pulse, zero read
        acc(32'h44, 1, 0, 1, 1);   // R5
        for (int k = 0; k < 800; k++) begin
            if (k % 40 == 0) begin
                ch_sec = 16'($urandom); ch_priv = 16'($urandom); ovr_flag = 16'($urandom);
            end
            if ($urandom_range(0, 4) == 0) step();
            else acc($urandom_range(0, 79), 1'($urandom), $urandom_range(0, 3),
                     1'($urandom), 1'($urandom));
        end
        step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule